// File: doc/BRIEF.md
# Ternary Rule Sub-Table Compiler

This block converts one ternary rule into the bit contents of its lookup sub-tables. A rule arrives as a value word, a care mask (a 1 means the key bit must equal the value bit, a 0 means the bit is ignored) and a rule number. The key is split into 5-bit slices. For every slice the block produces all 32 entries of that rule's truth table and streams them, one entry per handshake, to the table write port of a match array. Slice 0 covers key bits 4:0, slice 1 covers bits 9:5, and so on.

Table entry `a` of slice `s` is 1 exactly when `a` agrees with the rule's value on every bit the rule cares about inside that slice. Key positions past the key width in the last slice count as ignored bits. The block works alongside lookups in the match array. A flag per rule says whether that rule's tables are complete. The flag drops when an update of the rule begins and rises only after its final entry has been written, so a rule whose tables are only half rewritten is never reported as usable.

Both data interfaces use valid/ready. A rule is taken on a cycle where `rule_valid` and `rule_ready` are both high. Once taken, `rule_ready` stays low until the last table entry has been accepted. On the write side, an entry moves only on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the entry on offer is held unchanged.

Top module: `tcam_rule_compiler`

## Requirements
- R1: After reset, `rule_ready` is 1, `wr_valid` is 0, `upd_done` is 0 and every bit of `rule_live` is 0.
- R2: A rule is accepted on a clock edge where `rule_valid` and `rule_ready` are both 1. From the next cycle, `rule_ready` is 0 and `wr_valid` is 1 until the final table entry has been accepted.
- R3: Entries are sent in slice order starting at slice 0. Within a slice the addresses run 0 to 31 in ascending order. `wr_rule` carries the rule number that was accepted.
- R4: The entry bit `wr_bit` for address `a` (5 bits) of slice `s` is 1 if and only if, for every bit position b in 0..4 with key bit k = 5*s+b, either care[k] = 0 or a[b] = value[k].
- R5: A slice whose five care bits are all 0 produces a 1 at all 32 addresses.
- R6: A slice whose five care bits are all 1 produces exactly one 1, at the address equal to that slice's value bits.
- R7: Positions in the last slice beyond the key width are treated as ignored bits, whatever the care input is.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_slice`, `wr_addr`, `wr_rule` and `wr_bit` hold their values into the next cycle.
- R9: `upd_done` is 1 for exactly one cycle, in the cycle after the final entry is accepted. In that same cycle `rule_ready` is 1 again and `wr_valid` is 0.
- R10: `rule_live[i]` is 0 from the cycle after rule i is accepted, and is 1 from the cycle after its final entry is accepted. The flags of all other rules do not change.
- R11: Rule inputs offered while `rule_ready` is 0 are ignored. The write stream continues with the rule that was already accepted.
- R12: With `wr_ready` held at 1, a full update takes exactly 32 × ceil(KEY_W/5) write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_valid | input | 1 | A rule is offered |
| rule_ready | output | 1 | The block can take a rule |
| rule_value | input | KEY_W | Value bits of the rule |
| rule_care | input | KEY_W | Care mask; 1 = bit compared, 0 = ignored |
| rule_idx | input | IDX_W | Rule number to update |
| wr_valid | output | 1 | A table entry is offered |
| wr_ready | input | 1 | The table port accepts the entry |
| wr_slice | output | SLC_W | Key slice of the entry |
| wr_rule | output | IDX_W | Rule number of the entry |
| wr_addr | output | 5 | Table address of the entry |
| wr_bit | output | 1 | Entry contents |
| upd_done | output | 1 | One-cycle pulse after the final entry is written |
| rule_live | output | RULES | Per-rule flag: the rule's tables are complete |

## Verification
The bench builds the block with a 13-bit key and four rules. This gives three slices, and the last slice has only three real key bits. That makes the padding rule reachable, along with the wrap from one slice to the next and the final-entry condition across several slices. With four rules, the bench can also rewrite a rule that is already live and confirm that the flags of the other rules stay untouched. Random stalls on `wr_ready` and ignored rule offers during an update test the hold behaviour at both edges.

// File: rtl/tcam_cmp_pkg.sv
package tcam_cmp_pkg;
  localparam int SUB_W  = 5;
  localparam int SUB_DEP = 1 << SUB_W;

  // One truth-table entry: every cared bit of the address must equal the value.
  function automatic logic sub_entry(input logic [SUB_W-1:0] addr,
                                     input logic [SUB_W-1:0] val,
                                     input logic [SUB_W-1:0] care);
    return &((addr ~^ val) | ~care);
  endfunction
endpackage

// File: rtl/tcam_slice_eval.sv
module tcam_slice_eval
  import tcam_cmp_pkg::*;
#(
  parameter int KEY_W  = 40,
  parameter int NSLICE = (KEY_W + SUB_W - 1) / SUB_W,
  parameter int SLC_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
)(
  input  logic [KEY_W-1:0] value,
  input  logic [KEY_W-1:0] care,
  input  logic [SLC_W-1:0] slice,
  input  logic [SUB_W-1:0] addr,
  output logic             entry
);
  localparam int PAD_W = NSLICE * SUB_W;

  logic [PAD_W-1:0]  val_p;
  logic [PAD_W-1:0]  care_p;
  logic [NSLICE-1:0] per_slice;

  generate
    if (PAD_W > KEY_W) begin : g_pad
      assign val_p  = {{(PAD_W-KEY_W){1'b0}}, value};
      assign care_p = {{(PAD_W-KEY_W){1'b0}}, care};   // padding is ignored
    end else begin : g_nopad
      assign val_p  = value;
      assign care_p = care;
    end
  endgenerate

  generate
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign per_slice[s] = sub_entry(addr, val_p[s*SUB_W +: SUB_W],
                                      care_p[s*SUB_W +: SUB_W]);
    end
  endgenerate

  always_comb begin
    entry = 1'b0;
    for (int s = 0; s < NSLICE; s++)
      if (slice == SLC_W'(s)) entry = per_slice[s];
  end
endmodule

// File: rtl/tcam_fill_seq.sv
module tcam_fill_seq
  import tcam_cmp_pkg::*;
#(
  parameter int NSLICE = 8,
  parameter int SLC_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             accept,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SLC_W-1:0] slice,
  output logic [SUB_W-1:0] addr,
  output logic             fire_last,
  output logic             done
);
  localparam logic [SLC_W-1:0] LAST_SLC = SLC_W'(NSLICE - 1);

  logic busy;
  logic fire;
  logic at_top;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign out_valid = busy;
  assign fire      = busy && out_ready;
  assign at_top    = (addr == {SUB_W{1'b1}});
  assign fire_last = fire && at_top && (slice == LAST_SLC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      slice <= '0;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        slice <= '0;
        addr  <= '0;
      end else if (fire) begin
        if (fire_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (at_top) begin
          addr  <= '0;
          slice <= slice + 1'b1;
        end else begin
          addr <= addr + 1'b1;
        end
      end
    end
  end

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(slice) && $stable(addr)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !at_top) |=> (addr == $past(addr) + 1'b1) && $stable(slice));

  a_r3_slice_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && at_top && !fire_last) |=> (addr == '0) && (slice == $past(slice) + 1'b1));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fire_last) && req_ready && !out_valid));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_ready && out_valid && slice == '0 && addr == '0));
endmodule

// File: rtl/tcam_rule_flags.sv
module tcam_rule_flags #(
  parameter int RULES = 32,
  parameter int IDX_W = (RULES > 1) ? $clog2(RULES) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [RULES-1:0] live
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
    end else begin
      for (int i = 0; i < RULES; i++) begin
        if (clr_en && clr_idx == IDX_W'(i)) live[i] <= 1'b0;
        else if (set_en && set_idx == IDX_W'(i)) live[i] <= 1'b1;
      end
    end
  end

  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && int'(clr_idx) < RULES) |=> !live[$past(clr_idx)]);

  a_r10_set_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en && int'(set_idx) < RULES) |=> live[$past(set_idx)]);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !set_en) |=> $stable(live));
endmodule

// File: rtl/tcam_rule_compiler.sv
module tcam_rule_compiler
  import tcam_cmp_pkg::*;
#(
  parameter int KEY_W  = 40,
  parameter int RULES  = 32,
  parameter int NSLICE = (KEY_W + SUB_W - 1) / SUB_W,
  parameter int SLC_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  parameter int IDX_W  = (RULES > 1) ? $clog2(RULES) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rule_valid,
  output logic             rule_ready,
  input  logic [KEY_W-1:0] rule_value,
  input  logic [KEY_W-1:0] rule_care,
  input  logic [IDX_W-1:0] rule_idx,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [SLC_W-1:0] wr_slice,
  output logic [IDX_W-1:0] wr_rule,
  output logic [SUB_W-1:0] wr_addr,
  output logic             wr_bit,
  output logic             upd_done,
  output logic [RULES-1:0] rule_live
);
  logic [KEY_W-1:0] val_q;
  logic [KEY_W-1:0] care_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept;
  logic             fire_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      care_q <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      val_q  <= rule_value;
      care_q <= rule_care;
      idx_q  <= rule_idx;
    end
  end

  assign wr_rule = idx_q;

  tcam_fill_seq #(.NSLICE(NSLICE), .SLC_W(SLC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rule_valid),
    .req_ready (rule_ready),
    .accept    (accept),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .slice     (wr_slice),
    .addr      (wr_addr),
    .fire_last (fire_last),
    .done      (upd_done)
  );

  tcam_slice_eval #(.KEY_W(KEY_W), .NSLICE(NSLICE), .SLC_W(SLC_W)) u_eval (
    .value (val_q),
    .care  (care_q),
    .slice (wr_slice),
    .addr  (wr_addr),
    .entry (wr_bit)
  );

  tcam_rule_flags #(.RULES(RULES), .IDX_W(IDX_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (accept),
    .clr_idx (rule_idx),
    .set_en  (fire_last),
    .set_idx (idx_q),
    .live    (rule_live)
  );

  a_r11_rule_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !rule_ready) |=> $stable(wr_rule));

  a_r8_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ($stable(wr_bit) && $stable(wr_rule)));
endmodule

// File: tb/tcam_rule_compiler_tb.sv
module tcam_rule_compiler_tb;
  localparam int KEY_W = 13;
  localparam int RULES = 4;
  localparam int NS    = 3;
  localparam int SLC_W = 2;
  localparam int IDX_W = 2;
  localparam int TOTAL = 32 * NS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rule_valid = 1'b0;
  logic             rule_ready;
  logic [KEY_W-1:0] rule_value = '0;
  logic [KEY_W-1:0] rule_care = '0;
  logic [IDX_W-1:0] rule_idx = '0;
  logic             wr_valid;
  logic             wr_ready = 1'b1;
  logic [SLC_W-1:0] wr_slice;
  logic [IDX_W-1:0] wr_rule;
  logic [4:0]       wr_addr;
  logic             wr_bit;
  logic             upd_done;
  logic [RULES-1:0] rule_live;

  int n_run = 0;
  int n_fail = 0;
  int ones[NS];
  int first_one[NS];
  int wr_cycles;
  logic [RULES-1:0] live_exp = '0;

  always #5 clk = ~clk;

  tcam_rule_compiler #(.KEY_W(KEY_W), .RULES(RULES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rule_valid(rule_valid), .rule_ready(rule_ready),
    .rule_value(rule_value), .rule_care(rule_care), .rule_idx(rule_idx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_slice(wr_slice),
    .wr_rule(wr_rule), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .upd_done(upd_done), .rule_live(rule_live)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c,
                                   input int s, input int a);
    for (int b = 0; b < 5; b++) begin
      int k = s * 5 + b;
      if (k < KEY_W && c[k] && (v[k] != a[b])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic run_rule(input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c,
                          input logic [IDX_W-1:0] idx, input bit stall);
    int n = 0;
    @(negedge clk);
    chk(rule_ready == 1'b1, "R2 ready before offer", rule_ready, 1);
    rule_valid = 1'b1; rule_value = v; rule_care = c; rule_idx = idx;
    @(negedge clk);
    live_exp[idx] = 1'b0;
    chk(rule_ready == 1'b0, "R2 ready low after accept", rule_ready, 0);
    chk(rule_live == live_exp, "R10 flag cleared on start", rule_live, live_exp);
    for (int s = 0; s < NS; s++) begin ones[s] = 0; first_one[s] = -1; end
    wr_cycles = 0;
    while (n < TOTAL) begin
      // R11: unrelated rule offered while busy must be ignored
      rule_valid = 1'b1;
      rule_value = KEY_W'($urandom); rule_care = KEY_W'($urandom); rule_idx = IDX_W'($urandom);
      wr_ready = stall ? 1'($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      begin
        int es = n / 32;
        int ea = n % 32;
        logic eb = exp_bit(v, c, es, ea);
        if (!(wr_valid && int'(wr_slice) == es && int'(wr_addr) == ea))
          chk(1'b0, "R3 entry order", int'(wr_slice) * 32 + int'(wr_addr), n);
        else if (wr_rule != idx)
          chk(1'b0, "R11 rule number", wr_rule, idx);
        else if (wr_bit != eb)
          chk(1'b0, "R4 entry bit", wr_bit, eb);
        if (wr_ready) begin
          if (wr_bit) begin
            ones[es]++;
            if (first_one[es] < 0) first_one[es] = ea;
          end
          n++;
        end
      end
      wr_cycles++;
      @(negedge clk);
      if (n < TOTAL) chk(rule_ready == 1'b0, "R2 ready low while writing", rule_ready, 0);
    end
    rule_valid = 1'b0;
    wr_ready = 1'b1;
    live_exp[idx] = 1'b1;
    chk(upd_done == 1'b1, "R9 done pulse", upd_done, 1);
    chk(rule_ready == 1'b1 && wr_valid == 1'b0, "R9 idle with done", {rule_ready, wr_valid}, 2);
    chk(rule_live == live_exp, "R10 flag set on finish", rule_live, live_exp);
    if (!stall) chk(wr_cycles == TOTAL, "R12 update length", wr_cycles, TOTAL);
    @(negedge clk);
    chk(upd_done == 1'b0, "R9 done single cycle", upd_done, 0);
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk(rule_ready == 1'b1, "R1 ready at reset", rule_ready, 1);
    chk(wr_valid == 1'b0 && upd_done == 1'b0, "R1 idle outputs", {wr_valid, upd_done}, 0);
    chk(rule_live == '0, "R1 flags clear", rule_live, 0);
    rst_n = 1'b1;

    // slice0 all ignored, slice1 fully cared (value 10110b), slice2 fully cared on real bits
    run_rule(13'b101_10110_01011, 13'b111_11111_00000, 2'd1, 1'b0);
    chk(ones[0] == 32, "R5 all-ignored slice", ones[0], 32);
    chk(ones[1] == 1 && first_one[1] == 22, "R6 single location", first_one[1], 22);
    chk(ones[2] == 4, "R7 padding ignored", ones[2], 4);

    // care input high on every bit; padding still ignored
    run_rule('0, '1, 2'd3, 1'b1);
    chk(ones[2] == 4 && first_one[2] == 0, "R7 padding with full care", ones[2], 4);
    chk(ones[0] == 1 && first_one[0] == 0, "R6 zero value slice", first_one[0], 0);

    // rewrite a live rule, then random rules with stalls
    run_rule(13'h0aaa, 13'h1f0f, 2'd1, 1'b0);
    for (int r = 0; r < 8; r++)
      run_rule(KEY_W'($urandom), KEY_W'($urandom), IDX_W'($urandom), r[0]);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule